// File: doc/BRIEF.md
# Alarm and Countdown Interrupt Unit

This unit raises wake-up events for a real-time clock. Four alarm registers (minute, hour, day of month, weekday) each carry a disable bit. The enabled fields are compared with the current time supplied by the clock counters, and an alarm flag is set at the moment the comparison starts to hold. An 8-bit down-counter steps on one of four prescaler ticks, reloads itself at the end of each countdown and sets a timer flag.

Both flags pass through their enables onto one active-high interrupt line. The timer part of the interrupt can follow its flag (level mode) or emit a pulse of fixed width at each expiry (pulse mode). A gated square-wave output picks one of four prescaler waves. Software reaches the unit through a simple synchronous register write port.

Three small state machines run the unit. The alarm edge detector has the states `AM_CLEAR` and `AM_HELD`:
- `AM_CLEAR` moves to `AM_HELD` when a match appears, and that transition sets the flag.
- `AM_HELD` moves back to `AM_CLEAR` when the match goes away.

The countdown has the states `TC_STOP` and `TC_RUN`:
- It enters `TC_RUN` while the enable bit is 1.
- It returns to `TC_STOP` when the enable bit is cleared.

The pulse generator has the states `PS_IDLE` and `PS_ACTIVE`:
- An expiry moves `PS_IDLE` to `PS_ACTIVE`. An expiry during `PS_ACTIVE` restarts the width count.
- It returns to `PS_IDLE` after the width in fine ticks has elapsed.

Top module: `wake_event_unit`

Register map (address: contents):
- 0, control: bit0 alarm interrupt enable, bit1 timer interrupt enable, bit2 pulse mode, bit3 alarm flag, bit4 timer flag.
- 1 to 4, alarm registers for minute, hour, day and weekday: bit7 disable, low bits the BCD value.
- 5, clock output: bit7 enable, bits1:0 rate.
- 6, timer control: bit7 enable, bits1:0 source.
- 7, timer reload value.

## Requirements
- R1: When all four alarm disable bits (bit7 of addresses 1 to 4) are 1, the alarm flag is never set.
- R2: The alarm flag sets on the clock edge after every enabled field starts to equal the current time. It is not set again while that match persists. It is set again only after the match has gone away and reappears. A disabled field is ignored, but an enabled field that mismatches blocks the match.
- R3: A write to address 0 updates bit3 (alarm flag) and bit4 (timer flag) by AND: writing 1 keeps the flag and writing 0 clears it. Clearing one flag leaves the other as it was.
- R4: `irq` is (alarm flag AND bit0) OR (timer term AND bit1).
- R5: Timer source code (address 6, bits1:0) selects `tick_src` bit 0 (4096 Hz), 1 (64 Hz), 2 (1 Hz) or 3 (1/60 Hz). Ticks on unselected inputs, or while the enable bit (address 6, bit7) is 0, leave the count unchanged.
- R6: Each selected tick decrements the count. A tick at count 1 sets the timer flag and reloads the count. A count of 0 never expires. `timer_count` shows the live value.
- R7: With pulse mode (address 0, bit2) at 0, the timer term equals the timer flag.
- R8: With pulse mode at 1, each expiry drives the timer term high for a number of `tick_fine` (8192 Hz) ticks:
  - source 00: 2 ticks, or 1 tick when the reload value is 1;
  - source 01: 128 ticks, or 64 ticks when the reload value is 1;
  - sources 10 and 11: 128 ticks.
- R9: `clk_out` equals `wave_src` bit 0 (32768 Hz), 1 (1024 Hz), 2 (32 Hz) or 3 (1 Hz) per address 5 bits1:0. It is 0 unless both address 5 bit7 and `clkout_pin_en` are 1.
- R10: After reset, the clock-output enable is 1, the timer source is 11, and every alarm disable bit is 1. All flags, enables, the count and the reload value are 0.
- R11: A write to address 7 loads both the reload value and the live count at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_day | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current weekday |
| tick_src | input | 4 | One-cycle timer source ticks, indexed by source code |
| tick_fine | input | 1 | One-cycle 8192 Hz tick for pulse width |
| wave_src | input | 4 | Square waves for the clock output, indexed by rate code |
| clkout_pin_en | input | 1 | External clock-output enable |
| alarm_flag | output | 1 | Alarm flag |
| timer_flag | output | 1 | Timer flag |
| timer_count | output | 8 | Live countdown value |
| irq | output | 1 | Active-high interrupt |
| clk_out | output | 1 | Gated square-wave output |

## Verification
The assertions assume several things about the inputs:
- Each tick is a single-cycle strobe synchronous to `clk`.
- The current-time inputs change only between edges and hold stable otherwise.
- A write and a selected tick never target the count in the same cycle, except where a load deliberately takes priority.

The stimulus respects these assumptions. It drives every input at the falling edge, sends ticks and writes in separate tasks one cycle wide, and changes the time inputs only between tasks.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int N_ALM  = 4;
    localparam int N_SRC  = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_ALM0 = 4'd1;
    localparam logic [ADDR_W-1:0] A_CLK  = 4'd5;
    localparam logic [ADDR_W-1:0] A_TCTL = 4'd6;
    localparam logic [ADDR_W-1:0] A_TVAL = 4'd7;

    localparam int B_AIE = 0;
    localparam int B_TIE = 1;
    localparam int B_PM  = 2;
    localparam int B_AF  = 3;
    localparam int B_TF  = 4;
    localparam int B_ON  = 7;

    typedef enum logic {AM_CLEAR, AM_HELD}  alarm_st_t;
    typedef enum logic {TC_STOP, TC_RUN}    timer_st_t;
    typedef enum logic {PS_IDLE, PS_ACTIVE} pulse_st_t;
endpackage

// File: rtl/wake_alarm_match.sv
module wake_alarm_match
    import wake_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_ALM-1:0][7:0]  alm_i,
    input  logic [N_ALM-1:0][6:0]  cur_i,
    output logic                   set_o
);
    localparam logic [6:0] FMASK [N_ALM] = '{7'h7F, 7'h3F, 7'h3F, 7'h07};

    logic [N_ALM-1:0] hit;
    logic [N_ALM-1:0] dis;
    logic             match;
    alarm_st_t        state, nxt;

    for (genvar i = 0; i < N_ALM; i++) begin : g_field
        assign dis[i] = alm_i[i][7];
        assign hit[i] = dis[i] | ((alm_i[i][6:0] & FMASK[i]) == (cur_i[i] & FMASK[i]));
    end

    assign match = !(&dis) && (&hit);

    always_comb begin
        nxt = state;
        unique case (state)
            AM_CLEAR: if (match)  nxt = AM_HELD;
            AM_HELD:  if (!match) nxt = AM_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= AM_CLEAR;
        else        state <= nxt;
    end

    always_comb begin
        set_o = (state == AM_CLEAR) && match;
    end
endmodule

// File: rtl/wake_countdown.sv
module wake_countdown
    import wake_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int PW_SLOW = 128,
    parameter int PW_FAST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [1:0]       src_i,
    input  logic [N_SRC-1:0] tick_i,
    input  logic             tick_fine_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o,
    output logic             pulse_o
);
    localparam int PW_W = $clog2(PW_SLOW + 1);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    timer_st_t        tstate, tnxt;
    pulse_st_t        pstate, pnxt;
    logic [CNT_W-1:0] count_q, reload_q;
    logic [PW_W-1:0]  pw_q, pw_nxt, width;
    logic             step;

    assign step     = (tstate == TC_RUN) && tick_i[src_i] && !load_i;
    assign expire_o = step && (count_q == ONE);
    assign count_o  = count_q;

    always_comb begin
        unique case (src_i)
            2'd0:    width = (reload_q == ONE) ? PW_W'(PW_FAST / 2) : PW_W'(PW_FAST);
            2'd1:    width = (reload_q == ONE) ? PW_W'(PW_SLOW / 2) : PW_W'(PW_SLOW);
            default: width = PW_W'(PW_SLOW);
        endcase
    end

    always_comb begin
        tnxt = en_i ? TC_RUN : TC_STOP;
    end

    always_comb begin
        pnxt   = pstate;
        pw_nxt = pw_q;
        unique case (pstate)
            PS_IDLE: if (expire_o) begin
                pnxt   = PS_ACTIVE;
                pw_nxt = width;
            end
            PS_ACTIVE: if (expire_o) begin
                pw_nxt = width;
            end else if (tick_fine_i) begin
                if (pw_q <= PW_W'(1)) pnxt = PS_IDLE;
                pw_nxt = pw_q - PW_W'(1);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tstate <= TC_STOP;
            pstate <= PS_IDLE;
            pw_q   <= '0;
        end else begin
            tstate <= tnxt;
            pstate <= pnxt;
            pw_q   <= pw_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            reload_q <= '0;
        end else if (load_i) begin
            count_q  <= load_val_i;
            reload_q <= load_val_i;
        end else if (step && count_q != '0) begin
            count_q <= (count_q == ONE) ? reload_q : count_q - ONE;
        end
    end

    always_comb begin
        pulse_o = (pstate == PS_ACTIVE);
    end

    a_r6_reload_after_expire: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> count_q == $past(reload_q));
    a_r5_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate == TC_STOP && !load_i) |=> $stable(count_q));
    a_r8_pulse_from_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(expire_o));
endmodule

// File: rtl/wake_clk_gate.sv
module wake_clk_gate
    import wake_pkg::*;
(
    input  logic [N_SRC-1:0] wave_i,
    input  logic [1:0]       sel_i,
    input  logic             en_bit_i,
    input  logic             en_pin_i,
    output logic             clk_o
);
    always_comb begin
        clk_o = en_bit_i && en_pin_i && wave_i[sel_i];
    end
endmodule

// File: rtl/wake_event_unit.sv
module wake_event_unit
    import wake_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [6:0]        cur_min,
    input  logic [5:0]        cur_hour,
    input  logic [5:0]        cur_day,
    input  logic [2:0]        cur_wday,
    input  logic [N_SRC-1:0]  tick_src,
    input  logic              tick_fine,
    input  logic [N_SRC-1:0]  wave_src,
    input  logic              clkout_pin_en,
    output logic              alarm_flag,
    output logic              timer_flag,
    output logic [DATA_W-1:0] timer_count,
    output logic              irq,
    output logic              clk_out
);
    logic                  aie_q, tie_q, pm_q, af_q, tf_q;
    logic [N_ALM-1:0][7:0] alm_q;
    logic [N_ALM-1:0][6:0] cur_pk;
    logic                  ck_en_q, tm_en_q;
    logic [1:0]            ck_sel_q, tm_src_q;
    logic                  alarm_set, expire, pulse, tim_term, ctrl_wr;

    assign cur_pk  = {{4'd0, cur_wday}, {1'b0, cur_day}, {1'b0, cur_hour}, cur_min};
    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

    for (genvar i = 0; i < N_ALM; i++) begin : g_alm
        always_ff @(posedge clk) begin
            if (!rst_n)
                alm_q[i] <= 8'h80;
            else if (wr_en && wr_addr == A_ALM0 + ADDR_W'(i))
                alm_q[i] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aie_q <= 1'b0; tie_q <= 1'b0; pm_q <= 1'b0;
            af_q  <= 1'b0; tf_q  <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                aie_q <= wr_data[B_AIE];
                tie_q <= wr_data[B_TIE];
                pm_q  <= wr_data[B_PM];
                af_q  <= (af_q & wr_data[B_AF]) | alarm_set;
                tf_q  <= (tf_q & wr_data[B_TF]) | expire;
            end else begin
                af_q  <= af_q | alarm_set;
                tf_q  <= tf_q | expire;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_en_q <= 1'b1; ck_sel_q <= 2'b00;
            tm_en_q <= 1'b0; tm_src_q <= 2'b11;
        end else if (wr_en) begin
            if (wr_addr == A_CLK) begin
                ck_en_q  <= wr_data[B_ON];
                ck_sel_q <= wr_data[1:0];
            end
            if (wr_addr == A_TCTL) begin
                tm_en_q  <= wr_data[B_ON];
                tm_src_q <= wr_data[1:0];
            end
        end
    end

    wake_alarm_match u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .alm_i (alm_q),
        .cur_i (cur_pk),
        .set_o (alarm_set)
    );

    wake_countdown #(.CNT_W(DATA_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (tm_en_q),
        .src_i       (tm_src_q),
        .tick_i      (tick_src),
        .tick_fine_i (tick_fine),
        .load_i      (wr_en && wr_addr == A_TVAL),
        .load_val_i  (wr_data),
        .count_o     (timer_count),
        .expire_o    (expire),
        .pulse_o     (pulse)
    );

    wake_clk_gate u_gate (
        .wave_i   (wave_src),
        .sel_i    (ck_sel_q),
        .en_bit_i (ck_en_q),
        .en_pin_i (clkout_pin_en),
        .clk_o    (clk_out)
    );

    assign tim_term   = pm_q ? pulse : tf_q;
    assign irq        = (af_q & aie_q) | (tim_term & tie_q);
    assign alarm_flag = af_q;
    assign timer_flag = tf_q;

    a_r1_all_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((&{alm_q[3][7], alm_q[2][7], alm_q[1][7], alm_q[0][7]}) && !af_q) |=> !af_q);
    a_r2_rise_from_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(af_q) |-> $past(alarm_set));
    a_r3_one_keeps_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data[B_AF] && !alarm_set) |=> $stable(af_q));
    a_r3_zero_clears_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_data[B_AF] && !alarm_set) |=> !af_q);
    a_r7_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!pm_q && tie_q && tf_q) |-> irq);
endmodule

// File: tb/tb_wake_event_unit.sv
module tb_wake_event_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [6:0] cur_min = 7'h30;
    logic [5:0] cur_hour = 6'h12;
    logic [5:0] cur_day = 6'h15;
    logic [2:0] cur_wday = 3'd3;
    logic [3:0] tick_src = '0;
    logic       tick_fine = 1'b0;
    logic [3:0] wave_src = 4'b0001;
    logic       clkout_pin_en = 1'b1;
    logic       alarm_flag, timer_flag, irq, clk_out;
    logic [7:0] timer_count;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wake_event_unit dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0; #1;
    endtask

    task automatic tick(input int idx);
        @(negedge clk); tick_src[idx] = 1'b1;
        @(negedge clk); tick_src[idx] = 1'b0; #1;
    endtask

    task automatic fine(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_fine = 1'b1;
            @(negedge clk); tick_fine = 1'b0;
        end
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic t_reset;
        chk("R10 alarm_flag", alarm_flag, 0);
        chk("R10 timer_flag", timer_flag, 0);
        chk("R10 irq", irq, 0);
        chk("R10 count", timer_count, 0);
        chk("R10 clk_out enabled rate0", clk_out, 1);
        wave_src = 4'b1110; #1;
        chk("R10 clk_out follows rate0", clk_out, 0);
        tick(3);
        chk("R10 timer disabled", timer_count, 0);
    endtask

    task automatic t_alarm_off;
        wr(4'd1, 8'hB0); wr(4'd2, 8'h92); wr(4'd3, 8'h95); wr(4'd4, 8'h83);
        idle(3);
        chk("R1 all disabled no flag", alarm_flag, 0);
    endtask

    task automatic t_alarm_hit;
        wr(4'd1, 8'h30);
        chk("R2 flag not before edge", alarm_flag, 0);
        idle(1);
        chk("R2 flag on match", alarm_flag, 1);
        chk("R4 irq masked", irq, 0);
        wr(4'd0, 8'h19);
        chk("R4 irq alarm", irq, 1);
        chk("R3 write one keeps", alarm_flag, 1);
        wr(4'd0, 8'h11);
        idle(3);
        chk("R2 no reset while held", alarm_flag, 0);
        cur_min = 7'h31; idle(2);
        cur_min = 7'h30; idle(2);
        chk("R2 new match event", alarm_flag, 1);
    endtask

    task automatic t_alarm_multi;
        wr(4'd2, 8'h13);
        wr(4'd0, 8'h01);
        cur_min = 7'h31; idle(2);
        cur_min = 7'h30; idle(2);
        chk("R2 enabled mismatch blocks", alarm_flag, 0);
        wr(4'd2, 8'h12);
        idle(1);
        chk("R2 two fields match", alarm_flag, 1);
        wr(4'd1, 8'h80); wr(4'd2, 8'h80);
        wr(4'd0, 8'h00);
        chk("R3 zero clears", alarm_flag, 0);
    endtask

    task automatic t_timer_count;
        wr(4'd0, 8'h02);
        wr(4'd7, 8'd3);
        chk("R11 load count", timer_count, 3);
        wr(4'd6, 8'h80);
        tick(0); chk("R6 decrement", timer_count, 2);
        tick(1); chk("R5 unselected tick", timer_count, 2);
        tick(0); chk("R6 count one", timer_count, 1);
        chk("R7 no flag no irq", irq, 0);
        tick(0);
        chk("R6 reload", timer_count, 3);
        chk("R6 timer flag", timer_flag, 1);
        chk("R7 level irq", irq, 1);
    endtask

    task automatic t_timer_gating;
        wr(4'd6, 8'h00);
        tick(0); chk("R5 disabled hold", timer_count, 3);
        wr(4'd6, 8'h83);
        tick(2); chk("R5 src11 ignores 1Hz", timer_count, 3);
        tick(3); chk("R5 src11 minute tick", timer_count, 2);
        wr(4'd0, 8'h02);
        chk("R3 tf cleared", timer_flag, 0);
        chk("R7 irq follows clear", irq, 0);
        wr(4'd6, 8'h80);
        wr(4'd7, 8'd0);
        tick(0); tick(0);
        chk("R6 zero stays", timer_count, 0);
        chk("R6 zero no flag", timer_flag, 0);
    endtask

    task automatic t_flag_and;
        wr(4'd7, 8'd1);
        tick(0);
        chk("R6 reload one flag", timer_flag, 1);
        wr(4'd1, 8'h30);
        idle(1);
        chk("R2 alarm set", alarm_flag, 1);
        wr(4'd0, 8'h0A);
        chk("R3 tf cleared alone", timer_flag, 0);
        chk("R3 af kept", alarm_flag, 1);
        wr(4'd0, 8'h12);
        chk("R3 af cleared alone", alarm_flag, 0);
        chk("R3 tf stays clear", timer_flag, 0);
        cur_min = 7'h31; idle(2);
        cur_min = 7'h30; idle(2);
        chk("R4 alarm masked", irq, 0);
        wr(4'd0, 8'h09);
        chk("R4 alarm enabled", irq, 1);
        wr(4'd1, 8'h80);
        wr(4'd0, 8'h00);
    endtask

    task automatic t_pulse;
        wr(4'd0, 8'h06);
        wr(4'd7, 8'd2);
        tick(0); tick(0);
        chk("R8 pulse start", irq, 1);
        fine(1); chk("R8 src0 n2 mid", irq, 1);
        fine(1); chk("R8 src0 n2 end", irq, 0);
        chk("R8 flag set but irq low", timer_flag, 1);
        wr(4'd7, 8'd1);
        tick(0); chk("R8 src0 n1 start", irq, 1);
        fine(1); chk("R8 src0 n1 end", irq, 0);
        wr(4'd6, 8'h81);
        tick(1); chk("R8 src1 n1 start", irq, 1);
        fine(63); chk("R8 src1 n1 mid", irq, 1);
        fine(1); chk("R8 src1 n1 end", irq, 0);
        wr(4'd6, 8'h82);
        tick(2);
        fine(127); chk("R8 src2 mid", irq, 1);
        fine(1); chk("R8 src2 end", irq, 0);
    endtask

    task automatic t_clkout;
        wave_src = 4'b0100;
        wr(4'd5, 8'h82); chk("R9 rate2", clk_out, 1);
        wr(4'd5, 8'h81); chk("R9 rate1", clk_out, 0);
        wr(4'd5, 8'h82);
        clkout_pin_en = 1'b0; #1;
        chk("R9 pin gates", clk_out, 0);
        clkout_pin_en = 1'b1;
        wr(4'd5, 8'h02); chk("R9 bit gates", clk_out, 0);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_alarm_off;
        t_alarm_hit;
        t_alarm_multi;
        t_timer_count;
        t_timer_gating;
        t_flag_and;
        t_pulse;
        t_clkout;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule